// File: doc/BRIEF.md
# Glitch-Free Clock Output Gate

This block sits between a running source clock and the clock output pin. It decides whether the clock reaches the pin, using one active-low control input. A static function setting makes that input either an output enable or a power-down request. In output-enable function the source keeps running and only the output driver is switched off. In power-down function the block also asks the oscillator and PLL to stop, and it brings the clock back only after the clock source reports a qualified lock.

A second static setting picks how the output is disabled. Synchronous disabling turns the output off at a falling edge, so every pulse that starts on the pin is complete. Asynchronous disabling turns the output off at once, whatever the clock level. Re-enabling always happens at a falling edge, so the first pulse after a return is always complete.

The block works in the source-clock domain. Its reset is synchronous and active high. The control input is synchronized for the enable path, and the asynchronous kill path bypasses the synchronizer.

Top module: `clkout_gate`

## Requirements
- R1: While `rst` is high, `drv_en` and `pd_req` are 0. After `rst` falls with `ctrl_n` high, the output is enabled at a falling edge of `clk_src`.
- R2: When `cfg_pwrdn` = 0 (output-enable function), `pd_req` never goes to 1. A low `ctrl_n` turns `drv_en` off and leaves it off for as long as `ctrl_n` stays low.
- R3: When `cfg_async` = 1, a low `ctrl_n` drives `drv_en` and `clk_out` to 0 at once, including in the middle of a high clock phase.
- R4: When `cfg_async` = 0, a low `ctrl_n` turns `drv_en` off at the falling edge that follows the second rising edge after `ctrl_n` fell. `drv_en` never changes during a high phase, so the last pulse is complete.
- R5: `clk_out` follows `clk_src` while `drv_en` is 1, and is 0 while `drv_en` is 0.
- R6: In output-enable function, after `ctrl_n` returns high, `drv_en` rises at the falling edge that follows the second rising edge. `drv_en` only ever rises at a falling edge, so the first pulse is full width.
- R7: When `cfg_pwrdn` = 1, `pd_req` goes to 1 at the third rising edge after `ctrl_n` falls. `drv_en` is 0 whenever `pd_req` is 1.
- R8: `pd_req` returns to 0 at the third rising edge after `ctrl_n` returns high.
- R9: In power-down function, after `pd_req` falls, the output is enabled only after `pll_lock` has been sampled high on LOCK_SAMPLES (default 2) consecutive rising edges with `pd_req` low. A low sample restarts the count. The enable follows at the next falling edge.
- R10: In output-enable function, `pll_lock` has no effect on enabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock from the PLL/oscillator |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_n | input | 1 | Active-low control input (asynchronous) |
| cfg_pwrdn | input | 1 | Function select: 0 output enable, 1 power down |
| cfg_async | input | 1 | Disable mode: 0 synchronous, 1 asynchronous |
| pll_lock | input | 1 | Lock indication from the clock source |
| clk_out | output | 1 | Gated clock output |
| drv_en | output | 1 | Output driver enable (0 = high impedance) |
| pd_req | output | 1 | Power-down request to oscillator and PLL |

## Verification
The hardest case to reach is an asynchronous kill that lands inside a high clock phase. The stimulus drives `ctrl_n` low one nanosecond after a rising edge and samples `clk_out` one nanosecond later. The lock qualifier's restart is also hard to reach. To get there, the bench pulses `pll_lock` high for one cycle, drops it, and raises it again, then checks that the enable waits for two fresh consecutive samples. The timing of `pd_req` against the falling edge of `drv_en` is checked cycle by cycle in both disable modes.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    typedef enum logic {
        FUNC_OUT_EN   = 1'b0,
        FUNC_PWR_DOWN = 1'b1
    } ctl_func_e;

    typedef enum logic {
        DIS_SYNC  = 1'b0,
        DIS_ASYNC = 1'b1
    } dis_mode_e;

    typedef struct packed {
        logic run_req;   // wanted gate state, sampled on falling edge
        logic kill;      // immediate clear of the gate enable
    } gate_req_t;

    localparam int DEF_SYNC_STAGES  = 2;
    localparam int DEF_LOCK_SAMPLES = 2;

    // Output may run when the synchronized control is high; in
    // power-down function a qualified lock is also needed.
    function automatic logic want_output(ctl_func_e func, logic ctl_hi,
                                         logic lock_ok);
        if (func == FUNC_PWR_DOWN)
            return ctl_hi & lock_ok;
        return ctl_hi;
    endfunction

    function automatic logic want_powerdown(ctl_func_e func, logic ctl_hi);
        return (func == FUNC_PWR_DOWN) & ~ctl_hi;
    endfunction

endpackage

// File: rtl/clkgate_sync.sv
module clkgate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic r;
            always_ff @(posedge clk) begin
                if (rst) r <= 1'b0;
                else     r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[STAGES-2:0], d};
            end
            assign q = sh[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/clkgate_lockq.sv
module clkgate_lockq #(
    parameter int LOCK_SAMPLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,      // power-down active: count is cleared
    input  logic lock_in,
    output logic lock_ok
);
    localparam int CW = $clog2(LOCK_SAMPLES + 1);
    localparam logic [CW-1:0] TARGET = CW'(LOCK_SAMPLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || hold || !lock_in)
            cnt <= '0;
        else if (cnt != TARGET)
            cnt <= cnt + 1'b1;
    end

    assign lock_ok = (cnt == TARGET);
endmodule

// File: rtl/clkgate_cell.sv
module clkgate_cell
    import clkgate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  gate_req_t req,
    output logic      gate_en,
    output logic      clk_gated
);
    // Enable flop on the falling edge: it changes only while clk is low,
    // apart from the asynchronous kill, so the AND below cannot emit a
    // sliver on enable.
    always_ff @(negedge clk or posedge req.kill) begin
        if (req.kill)
            gate_en <= 1'b0;
        else if (rst)
            gate_en <= 1'b0;
        else
            gate_en <= req.run_req;
    end

    assign clk_gated = clk & gate_en;
endmodule

// File: rtl/clkout_gate.sv
module clkout_gate
    import clkgate_pkg::*;
#(
    parameter int SYNC_STAGES  = DEF_SYNC_STAGES,
    parameter int LOCK_SAMPLES = DEF_LOCK_SAMPLES
) (
    input  logic clk_src,
    input  logic rst,
    input  logic ctrl_n,
    input  logic cfg_pwrdn,
    input  logic cfg_async,
    input  logic pll_lock,
    output logic clk_out,
    output logic drv_en,
    output logic pd_req
);
    ctl_func_e func;
    dis_mode_e mode;
    logic      ctl_hi;
    logic      lock_ok;
    logic      pd_q;
    gate_req_t greq;
    logic      gate_en;

    assign func = ctl_func_e'(cfg_pwrdn);
    assign mode = dis_mode_e'(cfg_async);

    clkgate_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk_src),
        .rst (rst),
        .d   (ctrl_n),
        .q   (ctl_hi)
    );

    always_ff @(posedge clk_src) begin
        if (rst) pd_q <= 1'b0;
        else     pd_q <= want_powerdown(func, ctl_hi);
    end

    clkgate_lockq #(.LOCK_SAMPLES(LOCK_SAMPLES)) u_lockq (
        .clk     (clk_src),
        .rst     (rst),
        .hold    (pd_q),
        .lock_in (pll_lock),
        .lock_ok (lock_ok)
    );

    always_comb begin
        greq.run_req = want_output(func, ctl_hi, lock_ok);
        greq.kill    = (mode == DIS_ASYNC) & ~ctrl_n;
    end

    clkgate_cell u_cell (
        .clk       (clk_src),
        .rst       (rst),
        .req       (greq),
        .gate_en   (gate_en),
        .clk_gated (clk_out)
    );

    assign drv_en = gate_en;
    assign pd_req = pd_q;
endmodule

// File: rtl/clkout_gate_chk.sv
module clkout_gate_chk (
    input logic clk_src,
    input logic rst,
    input logic cfg_pwrdn,
    input logic cfg_async,
    input logic pll_lock,
    input logic clk_out,
    input logic drv_en,
    input logic pd_req
);
    logic en_at_rise;

    always_ff @(posedge clk_src) en_at_rise <= drv_en;

    // R5
    off_means_low_chk: assert property (@(negedge clk_src) disable iff (rst)
        !drv_en |-> !clk_out);

    // R7
    pd_gate_off_chk: assert property (@(posedge clk_src) disable iff (rst)
        pd_req |-> !drv_en);

    // R2
    oe_no_pd_chk: assert property (@(posedge clk_src) disable iff (rst)
        !cfg_pwrdn |=> !pd_req);

    // R4
    sync_high_stable_chk: assert property (@(negedge clk_src) disable iff (rst)
        !cfg_async |-> (drv_en == en_at_rise));

    // R6
    no_rise_in_high_chk: assert property (@(negedge clk_src) disable iff (rst)
        !en_at_rise |-> !drv_en);

    // R9
    pd_enable_lock_chk: assert property (@(posedge clk_src) disable iff (rst)
        ($rose(drv_en) && cfg_pwrdn) |-> $past(pll_lock));
endmodule

bind clkout_gate clkout_gate_chk u_chk (
    .clk_src   (clk_src),
    .rst       (rst),
    .cfg_pwrdn (cfg_pwrdn),
    .cfg_async (cfg_async),
    .pll_lock  (pll_lock),
    .clk_out   (clk_out),
    .drv_en    (drv_en),
    .pd_req    (pd_req)
);

// File: tb/clkout_gate_bench.sv
`timescale 1ns/1ps
module clkout_gate_bench;
    logic clk_src = 1'b0;
    logic rst = 1'b1;
    logic ctrl_n = 1'b0;
    logic cfg_pwrdn = 1'b1;
    logic cfg_async = 1'b0;
    logic pll_lock = 1'b0;
    logic clk_out, drv_en, pd_req;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk_src = ~clk_src;   // 125 MHz

    clkout_gate u_clkout_gate (
        .clk_src   (clk_src),
        .rst       (rst),
        .ctrl_n    (ctrl_n),
        .cfg_pwrdn (cfg_pwrdn),
        .cfg_async (cfg_async),
        .pll_lock  (pll_lock),
        .clk_out   (clk_out),
        .drv_en    (drv_en),
        .pd_req    (pd_req)
    );

    typedef struct packed {
        logic       pd;
        logic       asy;
        logic       cn;
        logic       lk;
        logic [3:0] wt;
        logic       ed;
        logic       ep;
        logic [3:0] rq;
    } vec_t;

    function automatic vec_t mk(int pd, int asy, int cn, int lk, int wt,
                                int ed, int ep, int rq);
        vec_t v;
        v.pd = pd[0]; v.asy = asy[0]; v.cn = cn[0]; v.lk = lk[0];
        v.wt = wt[3:0]; v.ed = ed[0]; v.ep = ep[0]; v.rq = rq[3:0];
        return v;
    endfunction

    // fields: pwrdn, async, ctrl_n, lock, cycles to wait, exp drv_en, exp pd_req, req
    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        mk(0,0,0,0,1,1,0,4),   // R4 still on after one cycle
        mk(0,0,0,0,1,0,0,4),   // R4 off at second falling edge
        mk(0,0,0,0,3,0,0,2),   // R2 stays off, no power-down
        mk(0,0,1,0,1,0,0,6),   // R6 not yet
        mk(0,0,1,0,1,1,0,10),  // R10 enabled with lock low
        mk(0,1,0,0,0,0,0,3),   // R3 immediate
        mk(0,1,0,0,2,0,0,2),   // R2 held off
        mk(0,1,1,1,1,0,0,6),
        mk(0,1,1,1,1,1,0,6),   // R6
        mk(1,0,0,1,2,0,0,4),   // R4 gate off, pd not yet
        mk(1,0,0,0,1,0,1,7),   // R7
        mk(1,0,1,0,2,0,1,8),   // R8 still requested
        mk(1,0,1,0,1,0,0,8),   // R8 released
        mk(1,0,1,0,4,0,0,9),   // R9 no lock, stays off
        mk(1,0,1,1,1,0,0,9),
        mk(1,0,1,0,1,0,0,9),   // R9 lock glitch restarts count
        mk(1,0,1,1,1,0,0,9),
        mk(1,0,1,1,1,1,0,9),   // R9 two samples -> on
        mk(1,1,0,1,0,0,0,3),   // R3
        mk(1,1,0,1,3,0,1,7),   // R7
        mk(1,1,1,0,3,0,0,8),   // R8
        mk(1,1,1,1,2,1,0,9)    // R9
    };

    task automatic chk(input string req, input logic act, input logic exp,
                       input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t",
                     req, what, act, exp, $time);
        end
    endtask

    initial begin
        // R1 reset state with power-down requested at the pin
        repeat (3) @(negedge clk_src);
        #1;
        chk("R1", drv_en, 1'b0, "drv_en in reset");
        chk("R1", pd_req, 1'b0, "pd_req in reset");
        cfg_pwrdn = 1'b0;
        ctrl_n = 1'b1;
        rst = 1'b0;
        @(negedge clk_src); #1;
        chk("R1", drv_en, 1'b0, "drv_en one cycle after reset");
        repeat (3) @(negedge clk_src);
        #1;
        chk("R1", drv_en, 1'b1, "drv_en after reset release");

        for (int i = 0; i < NV; i++) begin
            cfg_pwrdn = VECS[i].pd;
            cfg_async = VECS[i].asy;
            ctrl_n    = VECS[i].cn;
            pll_lock  = VECS[i].lk;
            repeat (int'(VECS[i].wt)) @(negedge clk_src);
            #1;
            chk($sformatf("R%0d", VECS[i].rq), drv_en, VECS[i].ed,
                $sformatf("vec %0d drv_en", i));
            chk($sformatf("R%0d", VECS[i].rq), pd_req, VECS[i].ep,
                $sformatf("vec %0d pd_req", i));
        end

        // R5 clock passes while enabled
        @(posedge clk_src); #1;
        chk("R5", clk_out, 1'b1, "clk_out high phase enabled");

        // R4 synchronous disable keeps the last pulse whole
        @(negedge clk_src); #1;
        cfg_pwrdn = 1'b0;
        cfg_async = 1'b0;
        ctrl_n = 1'b0;
        @(posedge clk_src);
        @(posedge clk_src); #3;
        chk("R4", clk_out, 1'b1, "last pulse intact");
        @(negedge clk_src); #1;
        chk("R4", drv_en, 1'b0, "off at falling edge");
        @(posedge clk_src); #1;
        chk("R5", clk_out, 1'b0, "clk_out low while disabled");

        // R6 re-enable only at a falling edge, first pulse full
        @(negedge clk_src); #1;
        ctrl_n = 1'b1;
        @(posedge clk_src);
        @(posedge clk_src); #1;
        chk("R6", clk_out, 1'b0, "no enable in high phase");
        @(negedge clk_src);
        @(posedge clk_src); #1;
        chk("R6", clk_out, 1'b1, "first pulse start");
        #2;
        chk("R6", clk_out, 1'b1, "first pulse late");

        // R3 asynchronous kill in the middle of a high phase
        @(negedge clk_src); #1;
        cfg_async = 1'b1;
        @(posedge clk_src); #1;
        ctrl_n = 1'b0;
        #1;
        chk("R3", clk_out, 1'b0, "clk_out cut mid-high");
        chk("R3", drv_en, 1'b0, "drv_en cut mid-high");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule